// File: doc/BRIEF.md
# Indexed Register Window

This block lets a host reach a large dword-addressed register space and a separate translation table through only two 32-bit I/O ports. The host first writes the index port. That write picks a dword offset and one of two back-ends. Each later access to the data port becomes a single-dword request to the chosen back-end at that offset. A data-port write is posted and does not stall the host. A data-port read holds the I/O side not-ready until the back-end answers.

Each back-end has a simple request/response interface: a one-cycle request pulse with a write flag, a byte address and write data, plus a read-valid strobe carrying the returned dword. The host side takes one access per cycle while `io_rdy` is high. Every read of any port is answered by a one-cycle `io_rvalid` pulse with the value on `io_rdata`. Apart from the synchronous reset, a function-level reset input clears the index.

Top module: `ioreg_window`

## Requirements
- R1: After `rst`, `io_rdy` is 1, `io_rvalid`, `reg_req` and `tbl_req` are 0, `io_rdata` is 0, and the index reads as 0.
- R2: A write with `io_addr` in 0..3 stores `io_wdata[20:0]` as the index. Bits 20:2 are the dword offset and bits 1:0 are the target code. A read of 0..3 gives `io_rvalid` on the next cycle, with bits 31:21 of `io_rdata` as zero and bits 20:0 equal to the stored index.
- R3: A `flr` pulse clears the index in the following cycle. It takes priority over an index write in the same cycle.
- R4: With target code 00, a write to `io_addr` 4..7 raises `reg_req` with `reg_we`=1 in the next cycle. `reg_addr` equals {offset, 2'b00} and `reg_wdata` equals the written data. `io_rdy` stays 1.
- R5: With target code 01, the same data-port write goes to the table port (`tbl_req`, `tbl_we`, `tbl_addr`, `tbl_wdata`) instead.
- R6: With target code 00 or 01, a read of 4..7 raises the selected request with the write flag at 0 in the next cycle. `io_rdy` is 0 from that cycle until the selected read-valid is seen. In the cycle after the read-valid, `io_rvalid` is 1, `io_rdata` holds the returned dword and `io_rdy` is 1.
- R7: With target code 10 or 11 (reserved), a data-port write raises no request. A data-port read raises no request and returns 0 with `io_rvalid` on the next cycle.
- R8: Accesses with `io_addr` 8..15 leave the index unchanged and raise no request. A read of those offsets returns 0 with `io_rvalid` on the next cycle.
- R9: While `io_rdy` is 0, `io_wr` and `io_rd` are ignored.
- R10: At most one request output is high in any cycle. No new request is issued while a read is pending.
- R11: When `io_wr` and `io_rd` are both high, only the write takes effect and no `io_rvalid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flr | input | 1 | Function-level reset, clears the index |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 4 | Host byte offset within the port range |
| io_wdata | input | 32 | Host write data |
| io_rdy | output | 1 | Host access accepted this cycle when high |
| io_rvalid | output | 1 | Read response strobe |
| io_rdata | output | 32 | Read response data |
| reg_req | output | 1 | Register-space request pulse |
| reg_we | output | 1 | Register-space write flag |
| reg_addr | output | 21 | Register-space byte address |
| reg_wdata | output | 32 | Register-space write data |
| reg_rvalid | input | 1 | Register-space read-valid |
| reg_rdata | input | 32 | Register-space read data |
| tbl_req | output | 1 | Table request pulse |
| tbl_we | output | 1 | Table write flag |
| tbl_addr | output | 21 | Table byte address |
| tbl_wdata | output | 32 | Table write data |
| tbl_rvalid | input | 1 | Table read-valid |
| tbl_rdata | input | 32 | Table read data |

## Verification
Directed sequences steer data-port traffic at each of the four target codes. This shows whether the steering decodes 00 and 01 correctly and whether it drops the reserved codes. Index writes with all-ones upper bits show whether the read-only bits leak. Reads are run with back-end latencies from zero to three cycles, and host strobes are given during the stall, to expose an early or late `io_rdy` release and any accepted stalled access. A random phase mixes offsets inside and outside the window, simultaneous strobes and `flr` pulses, including `flr` during a pending read. A behavioural model checks every cycle to catch ordering errors that the directed cases miss.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int NUM_BE = 2;

  typedef enum logic [1:0] {
    TGT_REGS  = 2'b00,
    TGT_TABLE = 2'b01,
    TGT_RSV_A = 2'b10,
    TGT_RSV_B = 2'b11
  } tgt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_st_e;
endpackage

// File: rtl/iw_index_reg.sv
module iw_index_reg #(
  parameter int OFF_W = 19,
  parameter int TGT_W = 2,
  localparam int IDX_W = OFF_W + TGT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_val,
  output logic [IDX_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || flr) q <= '0;
    else if (wr_en) q <= wr_val;
  end

  // R3: function-level reset wins over a same-cycle write
  p_flr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    flr |=> (q == '0));
endmodule

// File: rtl/iw_steer.sv
module iw_steer #(
  parameter int N_BE   = 2,
  parameter int TGT_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic [TGT_W-1:0]             tgt,
  input  logic [N_BE-1:0]              mux_sel,
  input  logic [N_BE-1:0]              be_rvalid,
  input  logic [N_BE-1:0][DATA_W-1:0]  be_rdata,
  output logic [N_BE-1:0]              dec_sel,
  output logic                         dec_ok,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data
);
  for (genvar i = 0; i < N_BE; i++) begin : g_dec
    assign dec_sel[i] = (tgt == TGT_W'(i));
  end

  assign dec_ok    = |dec_sel;
  assign rsp_valid = |(mux_sel & be_rvalid);

  always_comb begin
    rsp_data = '0;
    for (int i = 0; i < N_BE; i++)
      if (mux_sel[i]) rsp_data = rsp_data | be_rdata[i];
  end
endmodule

// File: rtl/iw_seq.sv
module iw_seq
  import iw_pkg::*;
#(
  parameter int N_BE   = 2,
  parameter int OFF_W  = 19,
  parameter int TGT_W  = 2,
  parameter int DATA_W = 32,
  parameter int IO_AW  = 4,
  localparam int IDX_W = OFF_W + TGT_W,
  localparam int BA_W  = OFF_W + 2,
  localparam int PW    = IO_AW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic [N_BE-1:0]   dec_sel,
  input  logic              dec_ok,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              idx_we,
  output logic [IDX_W-1:0]  idx_wval,
  output logic [N_BE-1:0]   wait_sel,
  output logic              io_rdy,
  output logic              io_rvalid,
  output logic [DATA_W-1:0] io_rdata,
  output logic [N_BE-1:0]   be_req,
  output logic              be_we,
  output logic [BA_W-1:0]   be_addr,
  output logic [DATA_W-1:0] be_wdata
);
  seq_st_e st;
  logic [PW-1:0] port_sel;
  logic hit_idx, hit_data, unused_lsb;
  logic [BA_W-1:0] baddr;
  logic [DATA_W-1:0] idx_word;

  assign port_sel   = io_addr[IO_AW-1:2];
  assign unused_lsb = ^io_addr[1:0];
  assign hit_idx    = (port_sel == PW'(0));
  assign hit_data   = (port_sel == PW'(1));
  assign baddr      = {idx[IDX_W-1:TGT_W], 2'b00};
  assign idx_word   = DATA_W'(idx);
  assign idx_we     = (st == ST_IDLE) && io_wr && hit_idx;
  assign idx_wval   = io_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      io_rdy    <= 1'b1;
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
      be_req    <= '0;
      be_we     <= 1'b0;
      be_addr   <= '0;
      be_wdata  <= '0;
      wait_sel  <= '0;
    end else begin
      io_rvalid <= 1'b0;
      be_req    <= '0;
      case (st)
        ST_IDLE: begin
          if (io_wr) begin
            if (hit_data && dec_ok) begin
              be_req   <= dec_sel;
              be_we    <= 1'b1;
              be_addr  <= baddr;
              be_wdata <= io_wdata;
            end
          end else if (io_rd) begin
            if (hit_data && dec_ok) begin
              be_req   <= dec_sel;
              be_we    <= 1'b0;
              be_addr  <= baddr;
              wait_sel <= dec_sel;
              io_rdy   <= 1'b0;
              st       <= ST_WAIT;
            end else begin
              io_rvalid <= 1'b1;
              io_rdata  <= hit_idx ? idx_word : '0;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            io_rdata  <= rsp_data;
            io_rvalid <= 1'b1;
            io_rdy    <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: requests never overlap
  p_one_req_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(be_req));

  // R10: nothing new is issued once a read has been pending a cycle
  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && $past(st == ST_WAIT)) |-> (be_req == '0));

  // R6: an accepted back-end read stalls the host side
  p_read_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && io_rdy && hit_data && dec_ok) |=> !io_rdy);

  // R6: a response releases the host with data
  p_read_done_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && rsp_valid) |=> (io_rvalid && io_rdy));

  // R7: reserved target drops a data write
  p_rsv_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_rdy && hit_data && !dec_ok) |=> (be_req == '0));
endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import iw_pkg::*;
#(
  parameter int OFF_W  = 19,
  parameter int TGT_W  = 2,
  parameter int DATA_W = 32,
  parameter int IO_AW  = 4,
  localparam int IDX_W = OFF_W + TGT_W,
  localparam int BA_W  = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_rdy,
  output logic              io_rvalid,
  output logic [DATA_W-1:0] io_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [BA_W-1:0]   reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rvalid,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              tbl_req,
  output logic              tbl_we,
  output logic [BA_W-1:0]   tbl_addr,
  output logic [DATA_W-1:0] tbl_wdata,
  input  logic              tbl_rvalid,
  input  logic [DATA_W-1:0] tbl_rdata
);
  logic [IDX_W-1:0] idx, idx_wval;
  logic idx_we, dec_ok, rsp_valid, be_we;
  logic [NUM_BE-1:0] dec_sel, wait_sel, be_req, be_rvalid;
  logic [NUM_BE-1:0][DATA_W-1:0] be_rdata;
  logic [DATA_W-1:0] rsp_data, be_wdata;
  logic [BA_W-1:0] be_addr;

  assign be_rvalid = {tbl_rvalid, reg_rvalid};
  assign be_rdata  = {tbl_rdata, reg_rdata};

  iw_index_reg #(.OFF_W(OFF_W), .TGT_W(TGT_W)) u_index (
    .clk(clk), .rst(rst), .flr(flr),
    .wr_en(idx_we), .wr_val(idx_wval), .q(idx)
  );

  iw_steer #(.N_BE(NUM_BE), .TGT_W(TGT_W), .DATA_W(DATA_W)) u_steer (
    .tgt(idx[TGT_W-1:0]), .mux_sel(wait_sel),
    .be_rvalid(be_rvalid), .be_rdata(be_rdata),
    .dec_sel(dec_sel), .dec_ok(dec_ok),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  iw_seq #(.N_BE(NUM_BE), .OFF_W(OFF_W), .TGT_W(TGT_W),
           .DATA_W(DATA_W), .IO_AW(IO_AW)) u_seq (
    .clk(clk), .rst(rst),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .idx(idx), .dec_sel(dec_sel), .dec_ok(dec_ok),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .idx_we(idx_we), .idx_wval(idx_wval), .wait_sel(wait_sel),
    .io_rdy(io_rdy), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata)
  );

  assign reg_req   = be_req[0];
  assign tbl_req   = be_req[1];
  assign reg_we    = be_we;
  assign tbl_we    = be_we;
  assign reg_addr  = be_addr;
  assign tbl_addr  = be_addr;
  assign reg_wdata = be_wdata;
  assign tbl_wdata = be_wdata;
endmodule

// File: tb/ioreg_window_test.sv
module ioreg_window_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, flr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic io_rdy, io_rvalid;
  logic [31:0] io_rdata;
  logic reg_req, reg_we, tbl_req, tbl_we;
  logic [20:0] reg_addr, tbl_addr;
  logic [31:0] reg_wdata, tbl_wdata;
  logic reg_rvalid = 1'b0, tbl_rvalid = 1'b0;
  logic [31:0] reg_rdata = '0, tbl_rdata = '0;

  ioreg_window uut (
    .clk(clk), .rst(rst), .flr(flr), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdy(io_rdy),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
  );

  int vectors = 0, fails = 0;
  bit finished = 1'b0;
  string cur = "R1";

  // reference model state
  int m_idx = 0, m_wtgt = 0;
  bit m_wait = 0;
  bit e_rdy = 1, e_rvalid = 0, e_rreq = 0, e_treq = 0, e_we = 0;
  int e_addr = 0;
  logic [31:0] e_rdata = '0, e_wdata = '0;

  // behavioural back-ends
  logic [31:0] rmem [64];
  logic [31:0] tmem [64];
  int lat_r = 0, lat_t = 2, cnt_r = 0, cnt_t = 0;
  bit pend_r = 0, pend_t = 0;
  logic [31:0] hold_r, hold_t;

  task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_idx = 0; m_wait = 0; e_rdy = 1; e_rvalid = 0; e_rdata = '0;
      e_rreq = 0; e_treq = 0;
      return;
    end
    e_rvalid = 0; e_rreq = 0; e_treq = 0;
    if (m_wait) begin
      if ((m_wtgt == 0) ? reg_rvalid : tbl_rvalid) begin
        e_rdata = (m_wtgt == 0) ? reg_rdata : tbl_rdata;
        e_rvalid = 1; m_wait = 0; e_rdy = 1;
      end
    end else if (io_wr) begin
      if (io_addr < 4) m_idx = int'(io_wdata) & 32'h1F_FFFF;
      else if (io_addr < 8) begin
        if ((m_idx & 3) == 0) e_rreq = 1;
        if ((m_idx & 3) == 1) e_treq = 1;
        e_we = 1; e_addr = m_idx & ~3; e_wdata = io_wdata;
      end
    end else if (io_rd) begin
      if (io_addr < 4) begin e_rdata = m_idx; e_rvalid = 1; end
      else if (io_addr < 8 && (m_idx & 3) < 2) begin
        m_wtgt = m_idx & 3; m_wait = 1; e_rdy = 0;
        e_rreq = (m_wtgt == 0); e_treq = (m_wtgt == 1);
        e_we = 0; e_addr = m_idx & ~3;
      end else begin e_rdata = '0; e_rvalid = 1; end
    end
    if (flr) m_idx = 0;
  endtask

  task automatic cyc();
    // back-end responses for this cycle
    reg_rvalid = 0; tbl_rvalid = 0;
    if (pend_r) begin
      if (cnt_r == 0) begin reg_rvalid = 1; reg_rdata = hold_r; pend_r = 0; end
      else cnt_r--;
    end
    if (pend_t) begin
      if (cnt_t == 0) begin tbl_rvalid = 1; tbl_rdata = hold_t; pend_t = 0; end
      else cnt_t--;
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(cur, "io_rdy", io_rdy, e_rdy);
    check(cur, "io_rvalid", io_rvalid, e_rvalid);
    check(cur, "io_rdata", io_rdata, e_rdata);
    check(cur, "reg_req", reg_req, e_rreq);
    check(cur, "tbl_req", tbl_req, e_treq);
    if (e_rreq) begin
      check(cur, "reg_we", reg_we, e_we);
      check(cur, "reg_addr", reg_addr, e_addr);
      if (e_we) check(cur, "reg_wdata", reg_wdata, e_wdata);
    end
    if (e_treq) begin
      check(cur, "tbl_we", tbl_we, e_we);
      check(cur, "tbl_addr", tbl_addr, e_addr);
      if (e_we) check(cur, "tbl_wdata", tbl_wdata, e_wdata);
    end
    if (reg_req) begin
      if (reg_we) rmem[reg_addr[7:2]] = reg_wdata;
      else begin pend_r = 1; cnt_r = lat_r; hold_r = rmem[reg_addr[7:2]]; end
    end
    if (tbl_req) begin
      if (tbl_we) tmem[tbl_addr[7:2]] = tbl_wdata;
      else begin pend_t = 1; cnt_t = lat_t; hold_t = tmem[tbl_addr[7:2]]; end
    end
  endtask

  task automatic iowr(logic [3:0] a, logic [31:0] d);
    io_wr = 1; io_addr = a; io_wdata = d;
    cyc();
    io_wr = 0;
  endtask

  task automatic iord(logic [3:0] a, output logic [31:0] v);
    io_rd = 1; io_addr = a;
    cyc();
    io_rd = 0;
    for (int g = 0; g < 20 && !io_rvalid; g++) cyc();
    v = io_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      rmem[i] = 32'hA500_0000 + i * 32'h0001_0101;
      tmem[i] = 32'h5A00_0000 + i * 32'h0003_0007;
    end
    // R1: reset state
    cur = "R1";
    cyc(); cyc();
    rst = 0;
    cyc();
    iord(4'd0, v); check("R1", "index after reset", v, 32'h0);

    // R2: index store, reserved upper bits read zero
    cur = "R2";
    iowr(4'd0, 32'hFFFF_FFFF);
    iord(4'd2, v); check("R2", "index all ones", v, 32'h001F_FFFF);
    iowr(4'd3, 32'h0012_3454);
    iord(4'd0, v); check("R2", "index pattern", v, 32'h0012_3454);

    // R4: register-space write, back-to-back
    cur = "R4";
    iowr(4'd0, 32'h0000_0014);
    iowr(4'd4, 32'hDEAD_BEEF);
    iowr(4'd7, 32'hCAFE_0001);
    cyc();
    check("R4", "register word 5", rmem[5], 32'hCAFE_0001);

    // R5: table write
    cur = "R5";
    iowr(4'd0, 32'h0000_0025);
    iowr(4'd5, 32'h1234_5678);
    cyc();
    check("R5", "table word 9", tmem[9], 32'h1234_5678);

    // R6: reads with several latencies
    cur = "R6";
    iord(4'd4, v); check("R6", "table read", v, 32'h1234_5678);
    iowr(4'd0, 32'h0000_0014);
    for (int l = 0; l < 4; l++) begin
      lat_r = l;
      iord(4'd6, v); check("R6", "register read", v, 32'hCAFE_0001);
    end

    // R9: strobes during a stall are ignored
    cur = "R9";
    lat_r = 3;
    io_rd = 1; io_addr = 4'd4; cyc(); io_rd = 0;
    iowr(4'd0, 32'h0000_0031);
    iowr(4'd4, 32'h0BAD_0BAD);
    cyc(); cyc();
    iord(4'd0, v); check("R9", "index kept during stall", v, 32'h0000_0014);
    check("R9", "register word 5 kept", rmem[5], 32'hCAFE_0001);

    // R3: flr alone, with a write, and during a pending read
    cur = "R3";
    flr = 1; cyc(); flr = 0;
    iord(4'd0, v); check("R3", "index after flr", v, 32'h0);
    iowr(4'd0, 32'h0000_0015);
    flr = 1; iowr(4'd0, 32'h0000_0099); flr = 0;
    iord(4'd0, v); check("R3", "flr beats write", v, 32'h0);
    iowr(4'd0, 32'h0000_0025);
    lat_t = 3;
    io_rd = 1; io_addr = 4'd4; cyc(); io_rd = 0;
    flr = 1; cyc(); flr = 0;
    for (int g = 0; g < 10 && !io_rvalid; g++) cyc();
    check("R3", "pending read finishes", io_rdata, 32'h1234_5678);
    iord(4'd0, v); check("R3", "index cleared mid-read", v, 32'h0);

    // R7: reserved targets
    cur = "R7";
    for (int t = 2; t < 4; t++) begin
      iowr(4'd0, 32'h0000_0014 | t);
      iowr(4'd4, 32'hFFFF_0000);
      iord(4'd4, v); check("R7", "reserved read", v, 32'h0);
    end
    check("R7", "register word 5 kept", rmem[5], 32'hCAFE_0001);

    // R8: offsets outside the window
    cur = "R8";
    iowr(4'd0, 32'h0000_0008);
    iowr(4'd8, 32'h0000_0001);
    iowr(4'd15, 32'hFFFF_FFFF);
    iord(4'd12, v); check("R8", "outside read", v, 32'h0);
    iord(4'd0, v); check("R8", "index unchanged", v, 32'h0000_0008);

    // R11: write wins over a simultaneous read
    cur = "R11";
    io_wr = 1; io_rd = 1; io_addr = 4'd0; io_wdata = 32'h0000_0044;
    cyc();
    io_wr = 0; io_rd = 0;
    check("R11", "no read response", io_rvalid, 1'b0);
    iord(4'd0, v); check("R11", "write took effect", v, 32'h0000_0044);

    // R10 and all: random mix against the model
    cur = "R10";
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = $urandom_range(0, 9);
      lat_r = $urandom_range(0, 3);
      lat_t = $urandom_range(0, 3);
      flr = ($urandom_range(0, 19) == 0);
      io_addr = (k < 7) ? 4'($urandom_range(0, 7)) : 4'($urandom_range(0, 15));
      io_wdata = $urandom;
      if (io_addr < 4) io_wdata[7:2] = 6'($urandom_range(0, 15));
      io_wr = ($urandom_range(0, 2) == 0);
      io_rd = ($urandom_range(0, 2) == 0);
      cyc();
    end
    io_wr = 0; io_rd = 0; flr = 0;
    repeat (8) cyc();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule